// File: doc/BRIEF.md
# Security-Partitioned Address Translation Buffer

This block is a small fully associative translation buffer for a processor that runs in either a secure or a non-secure world. A request carries a virtual address. The block first forms a modified virtual address by inserting the current world's process identifier into an empty top field. It then compares that address against cached page entries. It returns the physical address, an abort flag for a failed permission check, and the security attribute that the later bus access must carry.

Every entry is tagged with the world that filled it. A lookup can only hit entries of the current world. In the non-secure world the outgoing security attribute is always non-secure. In the secure world it comes from the attribute stored in the matching entry.

Entries are loaded through a plain write port, which a table walker or a test driver uses. The slot to replace is chosen in rotation. A flush strobe drops every entry of one chosen world and leaves the other world's entries untouched.

Top module: `world_tlb`

## Requirements
- R1: When VA[31:25] is zero, the modified address is {pid, VA[24:0]}, where pid is the 7-bit process identifier. Otherwise the modified address equals VA. Lookups compare the entry page against modified address bits [31:12].
- R2: The process identifier used is `pidSecure` when `curSecure`=1 and `pidNonSecure` when `curSecure`=0.
- R3: An entry can match only if it is valid and its world bit equals `curSecure` (1 = secure).
- R4: If a matching entry fails its permission check, `abort`=1 and `hit`=0, and `pa` and `nsOut` are zero. The check fails when `reqUser`=1 and the entry's user-allowed bit is 0, or when `reqWrite`=1 and the entry's write-allowed bit is 0.
- R5: On a hit while `curSecure`=0, `nsOut`=1.
- R6: On a hit while `curSecure`=1, `nsOut` equals the NS attribute stored in the entry.
- R7: The lookup is combinational. In the same cycle, a hit gives `pa` = {entry page, VA[11:0]}. When there is no match, or `reqValid`=0, `hit`, `abort`, `pa` and `nsOut` are all zero.
- R8: Reset invalidates every entry and sets the replacement slot to 0. Each `fillEn` cycle writes the slot and advances it by one, wrapping from ENTRIES-1 to 0.
- R9: `flushEn` clears only the entries whose world equals `flushSecure`. If a fill happens in the same cycle, the freshly written entry stays valid.
- R10: If several entries match, the one with the lowest slot index supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| curSecure | input | 1 | Current world, 1 = secure |
| pidSecure | input | 7 | Process identifier of the secure world |
| pidNonSecure | input | 7 | Process identifier of the non-secure world |
| reqValid | input | 1 | Lookup request present |
| reqVa | input | 32 | Virtual address of the request |
| reqUser | input | 1 | Request made at user privilege |
| reqWrite | input | 1 | Request is a write |
| hit | output | 1 | Translation valid |
| abort | output | 1 | Permission check failed |
| pa | output | 32 | Physical address |
| nsOut | output | 1 | Security attribute for the bus, 1 = non-secure |
| fillEn | input | 1 | Write one entry into the replacement slot |
| fillSecure | input | 1 | World of the written entry |
| fillMvaPage | input | 20 | Modified-address page of the written entry |
| fillPaPage | input | 20 | Physical page of the written entry |
| fillNs | input | 1 | NS attribute of the written entry |
| fillUserOk | input | 1 | User access allowed |
| fillWriteOk | input | 1 | Write access allowed |
| flushEn | input | 1 | Invalidate the entries of one world |
| flushSecure | input | 1 | World to invalidate |

## Verification
The hardest states to reach from the ports are two entries covering the same page and a flush that coincides with a fill. The stimulus reaches them as follows:
- It fills all eight slots, then fills a ninth entry. Because replacement rotates, that entry lands in slot 0, on top of an existing secure page that also sits in a higher slot. This exposes both the wrap-around and the lowest-index priority.
- It then issues a flush and a fill in the same cycle, with the fill aimed at the world being flushed.

After each such step, a sweep over every stored page runs in both address forms, both worlds and all four privilege combinations. A bench model predicts each result.

// File: rtl/world_tlb_pkg.sv
package world_tlb_pkg;
  localparam int ADDR_W   = 32;
  localparam int PAGE_LSB = 12;
  localparam int PID_W    = 7;
  localparam int PAGE_W   = ADDR_W - PAGE_LSB;

  typedef struct packed {
    logic              valid;
    logic              secure;
    logic [PAGE_W-1:0] mvaPage;
    logic [PAGE_W-1:0] paPage;
    logic              ns;
    logic              userOk;
    logic              writeOk;
  } tlbEntry_t;

  typedef struct packed {
    logic write;
    logic flush;
    logic flushSecure;
  } ctrlStrobe_t;
endpackage

// File: rtl/world_tlb_ctrl.sv
module world_tlb_ctrl
  import world_tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fillEn,
  input  logic             flushEn,
  input  logic             flushSecure,
  output ctrlStrobe_t      strobe,
  output logic [IDX_W-1:0] victimIdx
);
  logic [IDX_W-1:0] nextIdx;

  assign nextIdx = (victimIdx == IDX_W'(ENTRIES - 1)) ? '0 : victimIdx + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) victimIdx <= '0;
    else if (fillEn) victimIdx <= nextIdx;
  end

  always_comb begin
    strobe.write       = fillEn;
    strobe.flush       = flushEn;
    strobe.flushSecure = flushSecure;
  end
endmodule

// File: rtl/world_tlb_dpath.sv
module world_tlb_dpath
  import world_tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [IDX_W-1:0]  victimIdx,
  input  tlbEntry_t         fillEntry,
  input  logic              curSecure,
  input  logic [PID_W-1:0]  pidSecure,
  input  logic [PID_W-1:0]  pidNonSecure,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqVa,
  input  logic              reqUser,
  input  logic              reqWrite,
  output logic              hit,
  output logic              abort,
  output logic [ADDR_W-1:0] pa,
  output logic              nsOut
);
  tlbEntry_t         entries [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic [PID_W-1:0]  curPid;
  logic [ADDR_W-1:0] mva;
  logic [IDX_W-1:0]  selIdx;
  logic              anyMatch;
  logic              permFail;
  tlbEntry_t         sel;

  assign curPid = curSecure ? pidSecure : pidNonSecure;
  assign mva = (reqVa[ADDR_W-1 -: PID_W] == '0)
             ? {curPid, reqVa[ADDR_W-PID_W-1:0]} : reqVa;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    tlbEntry_t ent;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        ent <= '0;
      end else begin
        if (strobe.flush && ent.secure == strobe.flushSecure) ent.valid <= 1'b0;
        if (strobe.write && victimIdx == IDX_W'(g)) ent <= fillEntry;
      end
    end
    assign entries[g] = ent;
    assign match[g] = reqValid && ent.valid && (ent.secure == curSecure)
                    && (ent.mvaPage == mva[ADDR_W-1:PAGE_LSB]);
  end

  always_comb begin
    selIdx   = '0;
    anyMatch = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        selIdx   = IDX_W'(i);
        anyMatch = 1'b1;
      end
    end
  end

  assign sel      = entries[selIdx];
  assign permFail = (reqUser && !sel.userOk) || (reqWrite && !sel.writeOk);
  assign hit      = anyMatch && !permFail;
  assign abort    = anyMatch && permFail;
  assign pa       = hit ? {sel.paPage, reqVa[PAGE_LSB-1:0]} : '0;
  assign nsOut    = hit && (!curSecure || sel.ns);
endmodule

// File: rtl/world_tlb.sv
module world_tlb
  import world_tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        curSecure,
  input  logic [6:0]  pidSecure,
  input  logic [6:0]  pidNonSecure,
  input  logic        reqValid,
  input  logic [31:0] reqVa,
  input  logic        reqUser,
  input  logic        reqWrite,
  output logic        hit,
  output logic        abort,
  output logic [31:0] pa,
  output logic        nsOut,
  input  logic        fillEn,
  input  logic        fillSecure,
  input  logic [19:0] fillMvaPage,
  input  logic [19:0] fillPaPage,
  input  logic        fillNs,
  input  logic        fillUserOk,
  input  logic        fillWriteOk,
  input  logic        flushEn,
  input  logic        flushSecure
);
  ctrlStrobe_t      strobe;
  logic [IDX_W-1:0] victimIdx;
  tlbEntry_t        fillEntry;

  assign fillEntry = '{valid: 1'b1, secure: fillSecure, mvaPage: fillMvaPage,
                       paPage: fillPaPage, ns: fillNs, userOk: fillUserOk,
                       writeOk: fillWriteOk};

  world_tlb_ctrl #(.ENTRIES(ENTRIES)) ctrl_i (
    .clk(clk), .rstN(rstN), .fillEn(fillEn), .flushEn(flushEn),
    .flushSecure(flushSecure), .strobe(strobe), .victimIdx(victimIdx)
  );

  world_tlb_dpath #(.ENTRIES(ENTRIES)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .victimIdx(victimIdx),
    .fillEntry(fillEntry), .curSecure(curSecure), .pidSecure(pidSecure),
    .pidNonSecure(pidNonSecure), .reqValid(reqValid), .reqVa(reqVa),
    .reqUser(reqUser), .reqWrite(reqWrite), .hit(hit), .abort(abort),
    .pa(pa), .nsOut(nsOut)
  );
endmodule

// File: rtl/world_tlb_chk.sv
module world_tlb_chk #(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input logic             clk,
  input logic             rstN,
  input logic             curSecure,
  input logic             reqValid,
  input logic [31:0]      reqVa,
  input logic             hit,
  input logic             abort,
  input logic [31:0]      pa,
  input logic             nsOut,
  input logic             fillEn,
  input logic [IDX_W-1:0] victimIdx
);
  p_hit_abort_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(hit && abort));

  p_ns_forced_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hit && !curSecure) |-> nsOut);

  p_miss_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (pa == '0 && !nsOut));

  p_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (!hit && !abort));

  p_offset_r7: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (pa[11:0] == reqVa[11:0]));

  p_rr_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    fillEn |=> (victimIdx == (($past(victimIdx) == IDX_W'(ENTRIES - 1))
                              ? '0 : $past(victimIdx) + 1'b1)));

  p_rr_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !fillEn |=> $stable(victimIdx));
endmodule

bind world_tlb world_tlb_chk #(.ENTRIES(ENTRIES)) chk_i (
  .clk(clk), .rstN(rstN), .curSecure(curSecure), .reqValid(reqValid),
  .reqVa(reqVa), .hit(hit), .abort(abort), .pa(pa), .nsOut(nsOut),
  .fillEn(fillEn), .victimIdx(victimIdx)
);

// File: tb/world_tlb_tb_top.sv
`timescale 1ns/1ps
module world_tlb_tb_top;
  localparam int N = 8;
  localparam logic [6:0] PS = 7'h15;
  localparam logic [6:0] PN = 7'h2A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic curSecure = 1'b0;
  logic [6:0] pidSecure = PS, pidNonSecure = PN;
  logic reqValid = 1'b0, reqUser = 1'b0, reqWrite = 1'b0;
  logic [31:0] reqVa = '0;
  logic hit, abort, nsOut;
  logic [31:0] pa;
  logic fillEn = 1'b0, fillSecure = 1'b0, fillNs = 1'b0, fillUserOk = 1'b0, fillWriteOk = 1'b0;
  logic [19:0] fillMvaPage = '0, fillPaPage = '0;
  logic flushEn = 1'b0, flushSecure = 1'b0;

  always #2.5 clk = ~clk;

  world_tlb #(.ENTRIES(N)) dut_i (.*);

  // Bench model of the entry array
  logic        mV [N], mSec [N], mNs [N], mU [N], mW [N];
  logic [19:0] mMva [N], mPa [N];
  int          mPtr;
  logic [19:0] cPage [N];
  int nChecks = 0, nFails = 0;
  bit done = 0;

  task automatic compare(input string tag, input logic [34:0] act, input logic [34:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got hit/abort/ns/pa=%h expected %h (va=%h sec=%0b u=%0b w=%0b)",
               tag, act, exp, reqVa, curSecure, reqUser, reqWrite);
    end
  endtask

  // R1 R2 R3 R4 R5 R6 R7 R10 reference lookup
  task automatic lookup(input logic [31:0] va, input logic sec, input logic u,
                        input logic w, input logic v, input string tag);
    logic [31:0] mva;
    logic [34:0] exp;
    int idx;
    mva = (va[31:25] == 7'd0) ? {(sec ? PS : PN), va[24:0]} : va;
    idx = -1;
    for (int i = N - 1; i >= 0; i--)
      if (v && mV[i] && mSec[i] == sec && mMva[i] == mva[31:12]) idx = i;
    exp = '0;
    if (idx >= 0) begin
      if ((u && !mU[idx]) || (w && !mW[idx])) exp[33] = 1'b1;
      else begin
        exp[34] = 1'b1;
        exp[32] = sec ? mNs[idx] : 1'b1;
        exp[31:0] = {mPa[idx], va[11:0]};
      end
    end
    reqVa = va; curSecure = sec; reqUser = u; reqWrite = w; reqValid = v;
    #1;
    compare(tag, {hit, abort, nsOut, pa}, exp);
  endtask

  task automatic sweep(input string tag);
    for (int j = 0; j < N; j++)
      for (int k = 0; k < 2; k++)
        for (int c = 0; c < 8; c++) begin
          logic [31:0] va;
          va = k ? {cPage[j], 12'h5A0 + 12'(j)} : {7'd0, cPage[j][12:0], 12'h0F0 + 12'(j)};
          lookup(va, c[2], c[1], c[0], 1'b1, tag);
        end
    for (int c = 0; c < 8; c++) begin
      lookup(32'h0000_0123, c[2], c[1], c[0], 1'b1, tag);
      lookup(32'hFFFF_F000, c[2], c[1], c[0], 1'b1, tag);
    end
  endtask

  task automatic fill(input logic sec, input logic [19:0] mp, input logic [19:0] pp,
                      input logic ns, input logic u, input logic w, input logic fl,
                      input logic flSec);
    @(negedge clk);
    fillEn = 1'b1; fillSecure = sec; fillMvaPage = mp; fillPaPage = pp;
    fillNs = ns; fillUserOk = u; fillWriteOk = w; flushEn = fl; flushSecure = flSec;
    @(negedge clk);
    fillEn = 1'b0; flushEn = 1'b0;
    if (fl) for (int i = 0; i < N; i++) if (mSec[i] == flSec) mV[i] = 1'b0;
    mV[mPtr] = 1'b1; mSec[mPtr] = sec; mMva[mPtr] = mp; mPa[mPtr] = pp;
    mNs[mPtr] = ns; mU[mPtr] = u; mW[mPtr] = w;
    mPtr = (mPtr + 1) % N;
  endtask

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    for (int i = 0; i < N; i++) begin
      mV[i] = 0; mSec[i] = 0; mNs[i] = 0; mU[i] = 0; mW[i] = 0; mMva[i] = '0; mPa[i] = '0;
      if (i < 4) cPage[i] = {(i == 2) ? PS : (i[0] ? PS : PN), 13'(i + 1)};
      else       cPage[i] = {7'h40 + 7'(i), 13'(i)};
    end
    mPtr = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R8: reset leaves no valid entry
    sweep("R8 reset empty");
    // R1 R2 R3 R4 R5 R6 R7: full set of entries, both worlds
    for (int i = 0; i < N; i++)
      fill(i[0], cPage[i], 20'(32'h80000 + i * 32'h1111), i[1], !i[2] || i[0],
           i[1] || !i[0], 1'b0, 1'b0);
    sweep("R1/R2/R3/R4/R5/R6/R7 full");
    // R7: no request, no result
    for (int j = 0; j < N; j++) lookup({cPage[j], 12'h010}, j[0], 1'b0, 1'b0, 1'b0, "R7 idle");
    // R8 R10: ninth fill wraps into slot 0, duplicating a page held in slot 3
    fill(1'b1, cPage[3], 20'h12345, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    sweep("R8/R10 wrap duplicate");
    // R9: flush secure entries only
    @(negedge clk); flushEn = 1'b1; flushSecure = 1'b1;
    @(negedge clk); flushEn = 1'b0;
    for (int i = 0; i < N; i++) if (mSec[i]) mV[i] = 1'b0;
    sweep("R9 flush secure");
    // R9: flush non-secure while filling a non-secure entry
    fill(1'b0, cPage[0], 20'h0ABCD, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    sweep("R9 flush with fill");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule